// File: doc/BRIEF.md
# Page-Table Address Translator

This block turns a 32-bit virtual address into a 31-bit physical address. It looks the page up in a single-level page table held in a small dedicated RAM. The upper 20 bits of the virtual address form the page number, which indexes the table. The lower 12 bits are the byte offset inside a 4 KiB page. If the selected entry is marked present, its 19-bit frame number replaces the page number and the offset is carried across unchanged. If the entry is absent, the block raises a one-cycle fault pulse instead of a result. It also records the faulting page number in a register that stays put until software clears it.

Software owns the table contents. It fills and rewrites entries through a separate write port, typically after a fault, so that retrying the same access then succeeds. The table depth is a parameter. When fewer than 2^20 entries are built, the low page-number bits select the entry, which gives a cheap reduced-size model for simulation. Swapping pages and choosing victims are left to software.

Top module: `page_translator`

## Requirements
- R1: A request accepted on a clock edge with `reqValid` high produces its result one cycle later. If the entry is present, `respValid` is high for that one cycle and `respPaddr[30:12]` equals the entry's frame field.
- R2: On a successful translation, `respPaddr[11:0]` equals bits 11:0 of the requested virtual address.
- R3: An entry's presence flag is bit 31 of the written word. If it is 0, the result cycle shows `faultPulse` high, `respValid` low and `respPaddr` zero.
- R4: On a fault while no fault is pending, the page number (virtual address bits 31:12) is captured in `faultPage` and `faultPending` goes high on the following edge. While a fault is pending, later faults do not overwrite `faultPage`.
- R5: `faultClear` drops `faultPending` and returns `faultPage` to zero. If a new fault pulse occurs in the same cycle as `faultClear`, the new page is captured and the fault stays pending.
- R6: The frame number is taken from bits 18:0 of the written word. Bits 30:19 have no effect on any output.
- R7: When a table write and a translation of the same entry fall in the same cycle, the translation uses the entry as it was before the write.
- R8: After a faulting page's entry is rewritten as present, retrying the same virtual address translates successfully.
- R9: With a table of 2^TBL_AW entries, the entry index is page-number bits TBL_AW-1:0, so pages that agree in those bits share an entry.
- R10: After reset, `respValid`, `faultPulse` and `faultPending` are low, and `faultPage` and `respPaddr` are zero.
- R11: Requests on consecutive cycles each produce their own result on consecutive cycles, without bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqVaddr | input | 32 | Virtual address to translate |
| wrEn | input | 1 | Table write strobe |
| wrIndex | input | TBL_AW | Entry index to write |
| wrData | input | 32 | Entry word: bit 31 presence, bits 18:0 frame |
| faultClear | input | 1 | Release the captured fault |
| respValid | output | 1 | Physical address valid this cycle |
| respPaddr | output | 31 | Physical address |
| faultPulse | output | 1 | Translation faulted this cycle |
| faultPending | output | 1 | A fault page is held |
| faultPage | output | 20 | Captured faulting page number |

## Verification
The bench builds the translator with `TBL_AW = 4`, a 16-entry table. At this size the whole table can be filled in a few cycles. It also makes aliasing cheap to exercise: page 0x00003 and page 0xFFF03 land on the same entry. The address widths stay at their full 32/31/12-bit values. The full 20-bit page capture and the 19-bit frame substitution are therefore checked exactly as they would be in a full-size build.

// File: rtl/pt_pkg.sv
package pt_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture page/offset of an incoming request
    logic showResp;   // drive the physical address this cycle
    logic grabFault;  // load the fault page register
    logic dropFault;  // clear the fault page register
  } ptStrobes_t;

endpackage

// File: rtl/pt_table.sv
module pt_table #(
  parameter int IDX_W   = 8,
  parameter int DATA_W  = 20
) (
  input  logic              clk,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-before-write: a same-cycle read returns the old word
  always_ff @(posedge clk) begin
    if (wrEn) mem[wrIdx] <= wrData;
    if (rdEn) rdData <= mem[rdIdx];
  end
endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       present,
  input  logic       faultClear,
  output ptStrobes_t strobes,
  output logic       respValid,
  output logic       faultPulse,
  output logic       faultPending
);
  logic reqQ;
  logic pendQ;
  logic grab;

  always_ff @(posedge clk) begin
    if (!rstN) reqQ <= 1'b0;
    else       reqQ <= reqValid;
  end

  assign respValid  = reqQ & present;
  assign faultPulse = reqQ & ~present;
  // A new fault is taken if nothing is held or the held one is being released
  assign grab       = faultPulse & (~pendQ | faultClear);

  always_ff @(posedge clk) begin
    if (!rstN)           pendQ <= 1'b0;
    else if (grab)       pendQ <= 1'b1;
    else if (faultClear) pendQ <= 1'b0;
  end

  assign faultPending      = pendQ;
  assign strobes.latchReq  = reqValid;
  assign strobes.showResp  = respValid;
  assign strobes.grabFault = grab;
  assign strobes.dropFault = faultClear & ~grab;
endmodule

// File: rtl/pt_datapath.sv
module pt_datapath
  import pt_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 31,
  parameter int OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ptStrobes_t            strobes,
  input  logic [VA_W-1:0]       reqVaddr,
  input  logic [PA_W-OFF_W-1:0] frame,
  output logic [PA_W-1:0]       respPaddr,
  output logic [VA_W-OFF_W-1:0] faultPage
);
  localparam int PAGE_W = VA_W - OFF_W;

  logic [PAGE_W-1:0] pageQ;
  logic [OFF_W-1:0]  offsetQ;
  logic [PAGE_W-1:0] faultPageQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageQ   <= '0;
      offsetQ <= '0;
    end else if (strobes.latchReq) begin
      pageQ   <= reqVaddr[VA_W-1:OFF_W];
      offsetQ <= reqVaddr[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  faultPageQ <= '0;
    else if (strobes.grabFault) faultPageQ <= pageQ;
    else if (strobes.dropFault) faultPageQ <= '0;
  end

  assign respPaddr = strobes.showResp ? {frame, offsetQ} : '0;
  assign faultPage = faultPageQ;
endmodule

// File: rtl/page_translator.sv
module page_translator
  import pt_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 31,
  parameter int OFF_W   = 12,
  parameter int ENTRY_W = 32,
  parameter int TBL_AW  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [VA_W-1:0]       reqVaddr,
  input  logic                  wrEn,
  input  logic [TBL_AW-1:0]     wrIndex,
  input  logic [ENTRY_W-1:0]    wrData,
  input  logic                  faultClear,
  output logic                  respValid,
  output logic [PA_W-1:0]       respPaddr,
  output logic                  faultPulse,
  output logic                  faultPending,
  output logic [VA_W-OFF_W-1:0] faultPage
);
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int STORE_W = FRAME_W + 1;    // presence + frame only
  localparam int PRES_B  = ENTRY_W - 1;

  ptStrobes_t         strobes;
  logic [STORE_W-1:0] rdWord;
  logic [STORE_W-1:0] wrWord;

  assign wrWord = {wrData[PRES_B], wrData[FRAME_W-1:0]};

  pt_table #(.IDX_W(TBL_AW), .DATA_W(STORE_W)) u_table (
    .clk    (clk),
    .rdEn   (reqValid),
    .rdIdx  (reqVaddr[OFF_W +: TBL_AW]),
    .wrEn   (wrEn),
    .wrIdx  (wrIndex),
    .wrData (wrWord),
    .rdData (rdWord)
  );

  pt_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .present      (rdWord[STORE_W-1]),
    .faultClear   (faultClear),
    .strobes      (strobes),
    .respValid    (respValid),
    .faultPulse   (faultPulse),
    .faultPending (faultPending)
  );

  pt_datapath #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqVaddr  (reqVaddr),
    .frame     (rdWord[FRAME_W-1:0]),
    .respPaddr (respPaddr),
    .faultPage (faultPage)
  );
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 31,
  parameter int OFF_W   = 12,
  parameter int ENTRY_W = 32,
  parameter int TBL_AW  = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic [VA_W-1:0]       reqVaddr,
  input logic                  faultClear,
  input logic                  respValid,
  input logic [PA_W-1:0]       respPaddr,
  input logic                  faultPulse,
  input logic                  faultPending,
  input logic [VA_W-OFF_W-1:0] faultPage
);
  assert_result_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(respValid && faultPulse));

  assert_result_has_request_R1: assert property (@(posedge clk) disable iff (!rstN)
    (respValid || faultPulse) |-> $past(reqValid && rstN));

  assert_request_answered_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid && rstN) |-> (respValid || faultPulse));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> respPaddr[OFF_W-1:0] == $past(reqVaddr[OFF_W-1:0]));

  assert_fault_zero_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> respPaddr == '0);

  assert_fault_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    (faultPulse && !faultPending) |=> (faultPending && faultPage == $past(reqVaddr[VA_W-1:OFF_W], 2)));

  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rstN)
    (faultClear && !faultPulse) |=> !faultPending);

  assert_idle_page_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !faultPending |-> faultPage == '0);
endmodule

bind page_translator pt_checker #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ENTRY_W(ENTRY_W), .TBL_AW(TBL_AW)
) u_pt_checker (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqVaddr     (reqVaddr),
  .faultClear   (faultClear),
  .respValid    (respValid),
  .respPaddr    (respPaddr),
  .faultPulse   (faultPulse),
  .faultPending (faultPending),
  .faultPage    (faultPage)
);

// File: tb/test_page_translator.sv
module test_page_translator;
  localparam int TBL_AW = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        wrEn = 1'b0;
  logic [TBL_AW-1:0] wrIndex = '0;
  logic [31:0] wrData = '0;
  logic        faultClear = 1'b0;
  logic        respValid;
  logic [30:0] respPaddr;
  logic        faultPulse;
  logic        faultPending;
  logic [19:0] faultPage;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Sampled result of the last translation
  logic        sValid;
  logic        sFault;
  logic [30:0] sPaddr;

  always #4 clk = ~clk;   // 125 MHz

  page_translator #(.TBL_AW(TBL_AW)) i_page_translator (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .wrEn(wrEn), .wrIndex(wrIndex), .wrData(wrData), .faultClear(faultClear),
    .respValid(respValid), .respPaddr(respPaddr), .faultPulse(faultPulse),
    .faultPending(faultPending), .faultPage(faultPage)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic writeEntry(input int idx, input logic [31:0] data);
    wrEn = 1'b1; wrIndex = idx[TBL_AW-1:0]; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic translate(input logic [31:0] va);
    reqValid = 1'b1; reqVaddr = va;
    @(negedge clk);
    sValid = respValid; sFault = faultPulse; sPaddr = respPaddr;
    reqValid = 1'b0;
  endtask

  task automatic pulseClear();
    faultClear = 1'b1;
    @(negedge clk);
    faultClear = 1'b0;
  endtask

  task automatic testReset();
    check("R10 respValid", {31'd0, respValid}, 32'd0);
    check("R10 faultPulse", {31'd0, faultPulse}, 32'd0);
    check("R10 faultPending", {31'd0, faultPending}, 32'd0);
    check("R10 faultPage", {12'd0, faultPage}, 32'd0);
    check("R10 respPaddr", {1'b0, respPaddr}, 32'd0);
  endtask

  task automatic testHit();
    writeEntry(3, 32'h8001_2345);
    translate(32'h0000_3ABC);
    check("R1 valid", {31'd0, sValid}, 32'd1);
    check("R1 paddr", {1'b0, sPaddr}, {1'b0, 19'h12345, 12'hABC});
    check("R2 offset", {20'd0, sPaddr[11:0]}, 32'hABC);
    // bits 30:19 set must not leak into the frame
    writeEntry(5, 32'hFFF8_0001);
    translate(32'h0000_5123);
    check("R6 ignored bits", {1'b0, sPaddr}, {1'b0, 19'h00001, 12'h123});
    // alias: low 4 page bits 3 select entry 3
    translate(32'hFFF0_3FFF);
    check("R9 alias", {1'b0, sPaddr}, {1'b0, 19'h12345, 12'hFFF});
  endtask

  task automatic testFault();
    translate(32'h0000_7456);
    check("R3 pulse", {31'd0, sFault}, 32'd1);
    check("R3 no valid", {31'd0, sValid}, 32'd0);
    check("R3 paddr zero", {1'b0, sPaddr}, 32'd0);
    @(negedge clk);
    check("R4 pending", {31'd0, faultPending}, 32'd1);
    check("R4 page", {12'd0, faultPage}, 32'h00007);
    translate(32'h0000_9000);
    @(negedge clk);
    check("R4 held page", {12'd0, faultPage}, 32'h00007);
    // repair and retry
    writeEntry(7, 32'h8007_AAAA);
    translate(32'h0000_7456);
    check("R8 retry", {1'b0, sPaddr}, {1'b0, 19'h7AAAA, 12'h456});
    check("R8 retry valid", {31'd0, sValid}, 32'd1);
    pulseClear();
    check("R5 cleared", {31'd0, faultPending}, 32'd0);
    check("R5 page zero", {12'd0, faultPage}, 32'd0);
  endtask

  task automatic testClearRace();
    translate(32'h0000_9000);
    @(negedge clk);
    check("R5 pending before race", {31'd0, faultPending}, 32'd1);
    reqValid = 1'b1; reqVaddr = 32'h0000_A000;
    @(negedge clk);
    reqValid = 1'b0;
    faultClear = 1'b1;           // same cycle as the pulse for page A
    check("R5 race pulse", {31'd0, faultPulse}, 32'd1);
    @(negedge clk);
    faultClear = 1'b0;
    check("R5 race pending", {31'd0, faultPending}, 32'd1);
    check("R5 race page", {12'd0, faultPage}, 32'h0000A);
    pulseClear();
  endtask

  task automatic testWriteCollision();
    wrEn = 1'b1; wrIndex = 4'd2; wrData = 32'h8000_0222;
    translate(32'h0000_2010);
    wrEn = 1'b0;
    check("R7 old entry", {31'd0, sFault}, 32'd1);
    translate(32'h0000_2010);
    check("R7 new entry", {1'b0, sPaddr}, {1'b0, 19'h00222, 12'h010});
    pulseClear();
  endtask

  task automatic testBackToBack();
    reqValid = 1'b1; reqVaddr = 32'h0000_3001;
    @(negedge clk);
    check("R11 first", {1'b0, respPaddr}, {1'b0, 19'h12345, 12'h001});
    reqVaddr = 32'h0000_5002;
    @(negedge clk);
    check("R11 second", {1'b0, respPaddr}, {1'b0, 19'h00001, 12'h002});
    reqVaddr = 32'h0000_7003;
    @(negedge clk);
    check("R11 third", {1'b0, respPaddr}, {1'b0, 19'h7AAAA, 12'h003});
    reqValid = 1'b0;
    @(negedge clk);
    check("R11 idle after", {31'd0, respValid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    for (int i = 0; i < (1 << TBL_AW); i++) writeEntry(i, 32'h0000_0000);
    testHit();
    testFault();
    testClearRace();
    testWriteCollision();
    testBackToBack();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule